// File: doc/BRIEF.md
# Pulse-Synchronized Absolute Time Keeper

This block keeps absolute time, counted in 10 ms ticks, for a monitor-and-control interface board. A host places a pending time value into the block through a small register write port. The value does not take effect when it is written. It is held and armed, and it is copied into the running clock only when the next rising edge of the chosen timing pulse arrives. From then on the clock advances by one on every rising edge of the 10 ms pulse.

Four timing inputs reach the block: a 10 ms pulse, a 1 PPS pulse, a 10-second pulse and a 19.2 Hz transition signal. Each one passes through a two-flop synchronizer and a rising-edge detector. A 2-bit select register chooses the input that commits the pending time. A four-state machine tracks whether a value is armed and whether the clock has ever been loaded. Its states are ST_UNSET, ST_ARMED_COLD, ST_RUN and ST_ARMED_RUN. It has these transitions: T_ARM (ST_UNSET to ST_ARMED_COLD on a time write), T_FIRST_LOAD (ST_ARMED_COLD or ST_UNSET to ST_RUN on commit), T_REARM (ST_RUN to ST_ARMED_RUN on a time write) and T_RELOAD (ST_ARMED_RUN or ST_RUN to ST_RUN on commit). A write that does not commit leaves an armed state where it is.

Top module: `pulse_time_keeper`

## Requirements
- R1: After reset, valid_o is 0, time_o is 0 and no value is armed.
- R2: A write with wr_addr_i = 0 stores wr_data_i as the pending time and arms it. time_o does not change on that write.
- R3: A commit happens on the rising edge of the selected pulse while a value is armed. The pending value then appears on time_o, and valid_o goes to 1, three clock edges after the edge at which the pulse input is first sampled high.
- R4: Rising edges on pulse inputs that are not selected never commit the pending value.
- R5: A write with wr_addr_i = 1 sets the select from wr_data_i[1:0]. The codes are 0 for the 10 ms pulse, 1 for 1 PPS, 2 for the 10-second pulse and 3 for the 19.2 Hz signal. Reset selects 1 PPS. A select written in the same cycle as an edge takes effect only from the next cycle.
- R6: An edge of the selected pulse with no armed value does not reload time_o. A commit disarms the pending value.
- R7: While valid_o is 1, time_o rises by exactly one for each rising edge of the 10 ms pulse. A pulse held high for many cycles counts once.
- R8: Once valid_o is 1 it stays 1 until reset.
- R9: If a time write and the selected edge fall in the same cycle, the value written in that cycle commits.
- R10: When the 10 ms pulse is selected and a commit occurs, the committed value is loaded without an added tick.
- R11: time_o wraps from all ones to zero on a tick.
- R12: While valid_o is 0, 10 ms pulses do not advance time_o.
- R13: When several time writes come before a commit, the last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_10ms_i | input | 1 | 10 ms timing pulse (asynchronous) |
| pps_i | input | 1 | 1 PPS timing pulse (asynchronous) |
| pulse_10s_i | input | 1 | 10-second timing pulse (asynchronous) |
| trans_19hz_i | input | 1 | 19.2 Hz transition signal (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = pending time, 1 = pulse select |
| wr_data_i | input | TIME_W | Write data |
| time_o | output | TIME_W | Current absolute time in 10 ms ticks |
| valid_o | output | 1 | Time has been loaded at least once |

## Verification
A pulse input is sampled by the first synchronizer flop, reaches the second flop one edge later, and the detected rise acts at the third edge. So a commit or a tick shows on time_o three clock edges after the edge at which the input is first sampled high. A register write takes effect at the single edge that samples the strobe. The bench drives every input at a falling edge and keeps each pulse high for at least three cycles. It then waits several more cycles before it samples outputs at a falling edge, so every check comes after the result is due and never on the edge that makes it. The same-cycle case is timed on purpose: the strobe is raised at the falling edge right after the detected rise appears.

// File: rtl/ptk_pkg.sv
package ptk_pkg;

    localparam int NUM_PULSES = 4;
    localparam int SEL_W      = 2;

    // pulse select codes; also the index into the pulse vector
    localparam logic [SEL_W-1:0] SEL_10MS  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_1PPS  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_10S   = 2'd2;
    localparam logic [SEL_W-1:0] SEL_19HZ  = 2'd3;

    typedef enum logic [1:0] {
        ST_UNSET      = 2'd0,
        ST_ARMED_COLD = 2'd1,
        ST_RUN        = 2'd2,
        ST_ARMED_RUN  = 2'd3
    } keeper_state_t;

endpackage

// File: rtl/ptk_pulse_sync.sv
module ptk_pulse_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pulse_i,
    output logic [N-1:0] rise_o
);
    for (genvar g = 0; g < N; g++) begin : g_sync
        logic meta_q, sync_q, last_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                last_q <= 1'b0;
            end else begin
                meta_q <= pulse_i[g];
                sync_q <= meta_q;
                last_q <= sync_q;
            end
        end

        assign rise_o[g] = sync_q & ~last_q;
    end
endmodule

// File: rtl/ptk_cfg_regs.sv
module ptk_cfg_regs
    import ptk_pkg::*;
#(
    parameter int TIME_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [TIME_W-1:0] wr_data_i,
    output logic              wr_time_o,
    output logic [TIME_W-1:0] pending_o,
    output logic [SEL_W-1:0]  sel_o
);
    assign wr_time_o = wr_en_i & ~wr_addr_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_o <= '0;
            sel_o     <= SEL_1PPS;
        end else if (wr_en_i) begin
            if (wr_addr_i) sel_o     <= wr_data_i[SEL_W-1:0];
            else           pending_o <= wr_data_i;
        end
    end
endmodule

// File: rtl/ptk_arm_fsm.sv
module ptk_arm_fsm
    import ptk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_time_i,
    input  logic sel_rise_i,
    output logic armed_o,
    output logic valid_o,
    output logic commit_o
);
    keeper_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_UNSET;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        armed_o = 1'b0;
        valid_o = 1'b0;
        unique case (state_q)
            ST_UNSET:      begin armed_o = 1'b0; valid_o = 1'b0; end
            ST_ARMED_COLD: begin armed_o = 1'b1; valid_o = 1'b0; end
            ST_RUN:        begin armed_o = 1'b0; valid_o = 1'b1; end
            ST_ARMED_RUN:  begin armed_o = 1'b1; valid_o = 1'b1; end
        endcase
        commit_o = sel_rise_i & (armed_o | wr_time_i);
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNSET: begin
                if (commit_o)       state_d = ST_RUN;         // T_FIRST_LOAD
                else if (wr_time_i) state_d = ST_ARMED_COLD;  // T_ARM
            end
            ST_ARMED_COLD: begin
                if (commit_o)       state_d = ST_RUN;         // T_FIRST_LOAD
            end
            ST_RUN: begin
                if (commit_o)       state_d = ST_RUN;         // T_RELOAD
                else if (wr_time_i) state_d = ST_ARMED_RUN;   // T_REARM
            end
            ST_ARMED_RUN: begin
                if (commit_o)       state_d = ST_RUN;         // T_RELOAD
            end
        endcase
    end
endmodule

// File: rtl/ptk_time_counter.sv
module ptk_time_counter #(
    parameter int TIME_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [TIME_W-1:0] load_i,
    input  logic              run_i,
    input  logic              tick_i,
    output logic [TIME_W-1:0] time_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)              time_o <= '0;
        else if (commit_i)       time_o <= load_i;
        else if (run_i && tick_i) time_o <= time_o + 1'b1;
    end
endmodule

// File: rtl/pulse_time_keeper.sv
module pulse_time_keeper
    import ptk_pkg::*;
#(
    parameter int TIME_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_10ms_i,
    input  logic              pps_i,
    input  logic              pulse_10s_i,
    input  logic              trans_19hz_i,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [TIME_W-1:0] wr_data_i,
    output logic [TIME_W-1:0] time_o,
    output logic              valid_o
);
    logic [NUM_PULSES-1:0] pulse_vec;
    logic [NUM_PULSES-1:0] edge_rise;
    logic                  wr_time;
    logic [TIME_W-1:0]     pending;
    logic [SEL_W-1:0]      sel_q;
    logic                  armed;
    logic                  commit;
    logic [TIME_W-1:0]     load_val;

    // vector order follows the select codes
    assign pulse_vec = {trans_19hz_i, pulse_10s_i, pps_i, tick_10ms_i};

    ptk_pulse_sync #(.N(NUM_PULSES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (pulse_vec),
        .rise_o  (edge_rise)
    );

    ptk_cfg_regs #(.TIME_W(TIME_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .wr_time_o (wr_time),
        .pending_o (pending),
        .sel_o     (sel_q)
    );

    ptk_arm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_time_i  (wr_time),
        .sel_rise_i (edge_rise[sel_q]),
        .armed_o    (armed),
        .valid_o    (valid_o),
        .commit_o   (commit)
    );

    // a write in the commit cycle bypasses the pending register
    assign load_val = wr_time ? wr_data_i : pending;

    ptk_time_counter #(.TIME_W(TIME_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .load_i   (load_val),
        .run_i    (valid_o),
        .tick_i   (edge_rise[SEL_10MS]),
        .time_o   (time_o)
    );
endmodule

// File: rtl/ptk_checker.sv
module ptk_checker
    import ptk_pkg::*;
#(
    parameter int TIME_W = 40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PULSES-1:0] rise,
    input  logic [SEL_W-1:0]      sel,
    input  logic                  armed,
    input  logic                  commit,
    input  logic                  valid,
    input  logic [TIME_W-1:0]     time_v
);
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> valid);  // R8

    AST_LOAD_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(rise[sel]));  // R3

    AST_COLD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !commit) |=> $stable(time_v));  // R12

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !commit && rise[0]) |=> (time_v == $past(time_v) + 1'b1));  // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !commit && !rise[0]) |=> $stable(time_v));  // R4

    AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !armed);  // R6

    AST_COMMIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> rise[sel]);  // R4
endmodule

bind pulse_time_keeper ptk_checker #(.TIME_W(TIME_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (edge_rise),
    .sel    (sel_q),
    .armed  (armed),
    .commit (commit),
    .valid  (valid_o),
    .time_v (time_o)
);

// File: tb/pulse_time_keeper_bench.sv
module pulse_time_keeper_bench;
    localparam int TIME_W = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        pin = '0;   // 0:10ms 1:1PPS 2:10s 3:19.2Hz
    logic              wr_en = 1'b0;
    logic              wr_addr = 1'b0;
    logic [TIME_W-1:0] wr_data = '0;
    logic [TIME_W-1:0] time_o;
    logic              valid_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pulse_time_keeper #(.TIME_W(TIME_W)) u_pulse_time_keeper (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_10ms_i  (pin[0]),
        .pps_i        (pin[1]),
        .pulse_10s_i  (pin[2]),
        .trans_19hz_i (pin[3]),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .time_o       (time_o),
        .valid_o      (valid_o)
    );

    typedef struct packed {
        logic [1:0]        kind;   // 0 write, 1 pulse, 2 check
        logic [1:0]        arg;    // write addr or pulse index
        logic [TIME_W-1:0] data;   // write data or expected time
        logic              vld;    // expected valid
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 2'd0, 40'd0,   1'b0, 4'd1},  // R1 reset state
        '{2'd1, 2'd0, 40'd0,   1'b0, 4'd0},
        '{2'd2, 2'd0, 40'd0,   1'b0, 4'd12}, // R12 no tick before load
        '{2'd1, 2'd1, 40'd0,   1'b0, 4'd0},
        '{2'd2, 2'd0, 40'd0,   1'b0, 4'd6},  // R6 unarmed edge
        '{2'd0, 2'd0, 40'd100, 1'b0, 4'd0},
        '{2'd2, 2'd0, 40'd0,   1'b0, 4'd2},  // R2 write has no direct effect
        '{2'd1, 2'd2, 40'd0,   1'b0, 4'd0},
        '{2'd2, 2'd0, 40'd0,   1'b0, 4'd4},  // R4 unselected pulse
        '{2'd1, 2'd1, 40'd0,   1'b0, 4'd0},
        '{2'd2, 2'd0, 40'd100, 1'b1, 4'd3},  // R3 commit on 1PPS
        '{2'd1, 2'd0, 40'd0,   1'b0, 4'd0},
        '{2'd2, 2'd0, 40'd101, 1'b1, 4'd7},  // R7 tick
        '{2'd1, 2'd0, 40'd0,   1'b0, 4'd0},
        '{2'd2, 2'd0, 40'd102, 1'b1, 4'd8},  // R8 valid stays
        '{2'd1, 2'd1, 40'd0,   1'b0, 4'd0},
        '{2'd2, 2'd0, 40'd102, 1'b1, 4'd6},  // R6 disarmed after commit
        '{2'd0, 2'd1, 40'd2,   1'b0, 4'd0},
        '{2'd0, 2'd0, 40'd500, 1'b0, 4'd0},
        '{2'd0, 2'd0, 40'd600, 1'b0, 4'd0},
        '{2'd1, 2'd1, 40'd0,   1'b0, 4'd0},
        '{2'd2, 2'd0, 40'd102, 1'b1, 4'd5},  // R5 1PPS deselected
        '{2'd1, 2'd2, 40'd0,   1'b0, 4'd0},
        '{2'd2, 2'd0, 40'd600, 1'b1, 4'd13}, // R13 last write wins
        '{2'd0, 2'd1, 40'd3,   1'b0, 4'd0},
        '{2'd0, 2'd0, 40'd7,   1'b0, 4'd0},
        '{2'd1, 2'd3, 40'd0,   1'b0, 4'd0},
        '{2'd2, 2'd0, 40'd7,   1'b1, 4'd5},  // R5 19.2 Hz select
        '{2'd0, 2'd1, 40'd0,   1'b0, 4'd0},
        '{2'd0, 2'd0, 40'd50,  1'b0, 4'd0},
        '{2'd1, 2'd0, 40'd0,   1'b0, 4'd0},
        '{2'd2, 2'd0, 40'd50,  1'b1, 4'd10}  // R10 load without tick
    };

    task automatic check(input logic [TIME_W-1:0] exp_t, input logic exp_v, input int req);
        checks++;
        if (time_o !== exp_t || valid_o !== exp_v) begin
            errors++;
            $display("FAIL R%0d: time=%0d valid=%0b expected time=%0d valid=%0b",
                     req, time_o, valid_o, exp_t, exp_v);
        end
    endtask

    task automatic write_reg(input logic addr, input logic [TIME_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int idx, input int hold);
        @(negedge clk);
        pin[idx] = 1'b1;
        repeat (hold) @(negedge clk);
        pin[idx] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].kind)
                2'd0:    write_reg(VEC[i].arg[0], VEC[i].data);
                2'd1:    pulse(int'(VEC[i].arg), 3);
                default: check(VEC[i].data, VEC[i].vld, int'(VEC[i].req));
            endcase
        end
        pulse(0, 3);
        check(40'd51, 1'b1, 7);                 // R7 tick after reload

        // R1 mid-run reset clears; R5 select back to 1PPS
        do_reset();
        check('0, 1'b0, 1);                     // R1
        write_reg(1'b0, 40'd9);
        pulse(2, 3);
        check('0, 1'b0, 5);                     // R5 10s not selected after reset
        pulse(1, 3);
        check(40'd9, 1'b1, 5);                  // R5 1PPS default

        // R9 write in the same cycle as the detected edge
        write_reg(1'b0, 40'd11);
        @(negedge clk);
        pin[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 40'd22;
        @(negedge clk);
        wr_en = 1'b0; pin[1] = 1'b0;
        repeat (4) @(negedge clk);
        check(40'd22, 1'b1, 9);                 // R9

        // R11 wrap to zero
        write_reg(1'b0, {TIME_W{1'b1}});
        pulse(1, 3);
        check({TIME_W{1'b1}}, 1'b1, 11);        // R11 loaded all ones
        pulse(0, 3);
        check('0, 1'b1, 11);                    // R11 wrapped

        // R7 long-held pulse counts once
        pulse(0, 12);
        check(40'd1, 1'b1, 7);                  // R7

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule